// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block models, in synthesizable logic, the device side of a 12-bit serial converter's output pin. A readout controller under test drives an active-low chip select and a serial clock. The emulator answers on one data line, which has two jobs. During a conversion it is a busy/done flag: low while the conversion runs, high when it ends. After that it carries the result, most significant bit first, followed by zeros for as long as the controller keeps clocking.

The conversion length is a parameter counted in system-clock cycles. The result comes from a parallel sample input, which is captured when the start of a conversion is recognised. Both chip select and serial clock are asynchronous to the system clock. Each passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector. The data line is registered. Raising chip select at any point, including in the middle of a conversion, aborts the transaction and returns the line to its idle condition. While idle, the line is either released (output enable low) or driven to a fixed level, as a parameter chooses.

The block is intended for use in a simulation environment around a readout controller. It can also be placed in an FPGA test rig.

Top module: `serial_adc_emu`

## Requirements
- R1: After reset, and whenever a synchronized chip-select rise has been seen, `dataOe` equals `IDLE_DRIVE` and `dataOut` equals `IDLE_LEVEL`. With the defaults (IDLE_DRIVE=0), the line is released (`dataOe`=0).
- R2: A chip-select level first sampled low at system-clock edge k drives `dataOut` low with `dataOe`=1 right after edge k+SYNC_STAGES. Before that point, the idle condition is unchanged.
- R3: After the start of a conversion, `dataOut` stays low for exactly `CONV_CYCLES` system-clock cycles and then goes high (done) with `dataOe`=1.
- R4: `sampleIn` is captured in the same cycle that the conversion starts. Later changes to `sampleIn` do not alter the bits that are shifted out.
- R5: After done, each serial-clock fall drives the next result bit, MSB (bit 11) first. A fall first sampled at edge k changes `dataOut` right after edge k+SYNC_STAGES.
- R6: After all 12 result bits, every further serial-clock fall while chip select stays low drives `dataOut`=0.
- R7: Serial-clock falls that are recognised during the conversion phase are ignored. The first fall after done still produces the MSB.
- R8: A chip-select rise during a conversion aborts it. `dataOut` never shows done, the line returns to idle (R1), and the next chip-select fall starts a fresh conversion with a newly captured sample.
- R9: Serial-clock rises never change `dataOut`. After done, the line stays high through a rise until the next fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the controller (asynchronous) |
| sclk | input | 1 | Serial clock from the controller (asynchronous, idles low) |
| sampleIn | input | WIDTH | Value to report as the conversion result |
| dataOut | output | 1 | Serial data line value (busy/done flag, then result bits) |
| dataOe | output | 1 | Output enable for `dataOut`; 0 means released |

## Verification
The in-RTL properties are checked on every cycle:
- the datapath strobes are mutually exclusive;
- an abort returns the controller to idle;
- a start drives the line low and done drives it high;
- nothing shifts during a conversion or on a serial-clock rise;
- the held sample is stable between strobes;
- only zeros come out after the twelfth bit.

Some properties can only be shown by the bench's scenarios:
- the exact end-to-end latencies through the synchronizers;
- the exact length of the busy interval;
- MSB-first ordering of specific sample values;
- the sample being captured at the start even when it is overwritten later;
- a clean restart after an aborted conversion.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } emuState_t;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic load;   // capture sample, line low (busy)
    logic done;   // line high (conversion finished)
    logic shift;  // present next result bit
    logic idle;   // return line to idle condition
  } emuStrobe_t;

endpackage

// File: rtl/adcemu_edge.sv
module adcemu_edge #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rose,
  output logic fell
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= {STAGES{INIT}};
      lastQ <= INIT;
    end else begin
      syncQ[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        syncQ[i] <= syncQ[i-1];
      end
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign rose = syncQ[STAGES-1] & ~lastQ;
  assign fell = ~syncQ[STAGES-1] & lastQ;

endmodule

// File: rtl/adcemu_ctrl.sv
module adcemu_ctrl
  import adcemu_pkg::*;
#(
  parameter int CONV_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sclkFall,
  input  logic       sclkRise,
  output emuStrobe_t strb
);
  localparam int CNT_W = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);

  emuState_t        state, stateNxt;
  logic [CNT_W-1:0] convCnt, convCntNxt;

  always_comb begin
    stateNxt   = state;
    convCntNxt = convCnt;
    strb       = '0;
    if (csRise) begin
      stateNxt  = ST_IDLE;
      strb.idle = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            stateNxt   = ST_CONV;
            convCntNxt = '0;
            strb.load  = 1'b1;
          end
        end
        ST_CONV: begin
          if (convCnt == LAST_CNT) begin
            stateNxt  = ST_SHIFT;
            strb.done = 1'b1;
          end else begin
            convCntNxt = convCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sclkFall) strb.shift = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      convCnt <= '0;
    end else begin
      state   <= stateNxt;
      convCnt <= convCntNxt;
    end
  end

  // R2: strobes are mutually exclusive
  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.done, strb.shift, strb.idle}));

  // R8: a chip-select rise always lands in idle
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> state == ST_IDLE);

  // R7: no shifting while converting
  a_r7_conv_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_CONV |-> !strb.shift);

  // R9: a serial-clock rise never shifts
  a_r9_rise_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    sclkRise |-> !strb.shift);

endmodule

// File: rtl/adcemu_dp.sv
module adcemu_dp
  import adcemu_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter bit IDLE_DRIVE = 1'b0,
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  emuStrobe_t       strb,
  input  logic [WIDTH-1:0] sampleIn,
  output logic             dataOut,
  output logic             dataOe
);
  localparam int BC_W = $clog2(WIDTH + 1);
  localparam logic [BC_W-1:0] BC_MAX = BC_W'(WIDTH);

  logic [WIDTH-1:0] shReg;
  logic [BC_W-1:0]  bitsOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      bitsOut <= '0;
      dataOut <= IDLE_LEVEL;
      dataOe  <= IDLE_DRIVE;
    end else begin
      if (strb.load) begin
        shReg   <= sampleIn;
        bitsOut <= '0;
        dataOut <= 1'b0;
        dataOe  <= 1'b1;
      end else if (strb.done) begin
        dataOut <= 1'b1;
        dataOe  <= 1'b1;
      end else if (strb.shift) begin
        dataOut <= shReg[WIDTH-1];
        shReg   <= {shReg[WIDTH-2:0], 1'b0};
        if (bitsOut != BC_MAX) bitsOut <= bitsOut + 1'b1;
      end else if (strb.idle) begin
        dataOut <= IDLE_LEVEL;
        dataOe  <= IDLE_DRIVE;
      end
    end
  end

  // R2: start drives busy low
  a_r2_load_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (dataOut == 1'b0) && dataOe);

  // R3: done drives the line high
  a_r3_done_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> dataOut && dataOe);

  // R1: idle strobe restores the idle condition
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> (dataOe == IDLE_DRIVE) && (dataOut == IDLE_LEVEL));

  // R4: the held sample only moves on load or shift
  a_r4_hold_sample: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(shReg));

  // R6: past the last result bit only zeros come out
  a_r6_zero_tail: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && bitsOut == BC_MAX) |=> dataOut == 1'b0);

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
  import adcemu_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_DRIVE  = 1'b0,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic [WIDTH-1:0] sampleIn,
  output logic             dataOut,
  output logic             dataOe
);
  logic       csRise, csFall, sclkRise, sclkFall;
  emuStrobe_t strb;

  adcemu_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_csEdge (
    .clk(clk), .rstN(rstN), .din(csN), .rose(csRise), .fell(csFall)
  );

  adcemu_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclkEdge (
    .clk(clk), .rstN(rstN), .din(sclk), .rose(sclkRise), .fell(sclkFall)
  );

  adcemu_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .strb(strb)
  );

  adcemu_dp #(.WIDTH(WIDTH), .IDLE_DRIVE(IDLE_DRIVE), .IDLE_LEVEL(IDLE_LEVEL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/sim_serial_adc_emu.sv
`timescale 1ns/1ps
module sim_serial_adc_emu;
  localparam int W    = 12;
  localparam int CONV = 20;
  localparam int NS   = 2;
  localparam bit IDRV = 1'b0;
  localparam bit ILVL = 1'b1;
  localparam int H    = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         csN = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         dataOut, dataOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_adc_emu #(.WIDTH(W), .CONV_CYCLES(CONV), .SYNC_STAGES(NS),
                   .IDLE_DRIVE(IDRV), .IDLE_LEVEL(ILVL)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleIn(sampleIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // ---------------- behavioural reference model ----------------
  bit csQ[$];
  bit skQ[$];
  int mMode;     // 0 idle, 1 converting, 2 result phase
  int mWait;
  int mWord;
  bit expOut, expOe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ.delete(); skQ.delete();
      for (int i = 0; i < NS + 2; i++) begin csQ.push_front(1'b1); skQ.push_front(1'b0); end
      mMode = 0; mWait = 0; mWord = 0; expOut = ILVL; expOe = IDRV;
    end else begin
      bit cF, cR, sF;
      csQ.push_front(csN);  void'(csQ.pop_back());
      skQ.push_front(sclk); void'(skQ.pop_back());
      cF = csQ[NS+1] && !csQ[NS];
      cR = !csQ[NS+1] && csQ[NS];
      sF = skQ[NS+1] && !skQ[NS];
      if (cR) begin
        mMode = 0; expOut = ILVL; expOe = IDRV;
      end else if (mMode == 0) begin
        if (cF) begin mMode = 1; mWait = CONV; mWord = int'(sampleIn); expOut = 0; expOe = 1; end
      end else if (mMode == 1) begin
        mWait--;
        if (mWait == 0) begin mMode = 2; expOut = 1; end
      end else begin
        if (sF) begin
          expOut = mWord[W-1];
          mWord  = (mWord << 1) & ((1 << W) - 1);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      string tag;
      tag = (mMode == 0) ? "R1" : (mMode == 1) ? "R3" : "R5";
      nChecks++;
      if (dataOe !== expOe || (expOe && dataOut !== expOut)) begin
        nFails++;
        $display("FAIL %s model compare t=%0t: got out=%b oe=%b, expected out=%b oe=%b",
                 tag, $time, dataOut, dataOe, expOut, expOe);
      end
    end
  end

  // ---------------- directed scenarios ----------------
  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h, expected %0h", req, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Start a conversion and verify latency and busy length (R2, R3).
  task automatic startConv(input logic [W-1:0] s);
    int lowCnt;
    @(negedge clk);
    sampleIn = s;
    csN = 1'b0;
    ticks(NS);
    check("R2 idle before latency", int'(dataOe), int'(IDRV));
    ticks(1);
    check("R2 busy low", int'({dataOe, dataOut}), 2);
    lowCnt = 1;
    while (dataOut == 1'b0 && lowCnt < 10 * CONV) begin
      ticks(1);
      if (dataOut == 1'b0) lowCnt++;
    end
    check("R3 busy length", lowCnt, CONV);
    check("R3 done high", int'({dataOe, dataOut}), 3);
  endtask

  task automatic readBits(input int n, output logic [63:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; ticks(H);
      sclk = 1'b0; ticks(H);
      got = {got[62:0], dataOut};
    end
  endtask

  task automatic endConv();
    csN = 1'b1;
    ticks(NS + 2);
    check("R1 idle after cs high", int'(dataOe), int'(IDRV));
  endtask

  initial begin
    logic [63:0] bits;
    ticks(3);
    rstN = 1'b1;
    ticks(2);
    check("R1 reset idle", int'(dataOe), int'(IDRV));

    // R5/R6: basic readout with trailing zeros; R9: rise keeps done flag
    startConv(12'hA5C);
    sclk = 1'b1; ticks(H);
    check("R9 rise keeps done", int'(dataOut), 1);
    sclk = 1'b0; ticks(H);
    check("R5 MSB first", int'(dataOut), 1);
    readBits(15, bits);
    check("R5 R6 word A5C", int'(bits[14:0]), 15'h25C0);
    endConv();

    // R4: sample changed after start has no effect
    startConv(12'h3E1);
    sampleIn = 12'hFFF;
    readBits(24, bits);
    check("R4 R6 captured 3E1", int'(bits[23:0]), 24'h3E1000);
    endConv();

    // R7: serial clock activity during conversion ignored
    @(negedge clk);
    sampleIn = 12'h801;
    csN = 1'b0;
    ticks(2);
    for (int p = 0; p < 2; p++) begin
      sclk = 1'b1; ticks(2); sclk = 1'b0; ticks(2);
    end
    while (dataOut == 1'b0) ticks(1);
    readBits(12, bits);
    check("R7 full word after ignored clocks", int'(bits[11:0]), 12'h801);
    endConv();

    // R8: abort during conversion, then fresh conversion
    @(negedge clk);
    sampleIn = 12'h123;
    csN = 1'b0;
    ticks(NS + 6);
    check("R8 busy before abort", int'({dataOe, dataOut}), 2);
    csN = 1'b1;
    ticks(NS);
    check("R8 no done before abort lands", int'({dataOe, dataOut}), 2);
    ticks(1);
    check("R8 idle after abort", int'(dataOe), int'(IDRV));
    ticks(CONV + 4);
    check("R8 stays idle", int'(dataOe), int'(IDRV));
    startConv(12'h0F0);
    readBits(13, bits);
    check("R8 fresh sample", int'(bits[12:0]), 13'h01E0);
    endConv();

    // all-ones and all-zeros patterns (R5, R6)
    startConv(12'hFFF);
    readBits(14, bits);
    check("R5 R6 all ones", int'(bits[13:0]), 14'h3FFC);
    endConv();
    startConv(12'h000);
    readBits(12, bits);
    check("R5 all zeros", int'(bits[11:0]), 0);
    endConv();

    ticks(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule